// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is the serial engine of an SPI master that takes its work one frame at a time. Each frame arrives as an entry made of a two-bit selector and a data word. The selector does two jobs at once. It chooses one of four stored attribute sets, which give the frame length, clock polarity, clock phase, bit order and SCK divider. It also chooses which of four active-low chip selects is driven for that frame. Because every entry carries its own selector, two frames in a row may use entirely different timing and target different peripherals.

The data word is loaded into a shift register and clocked out on `mosi` while the block generates SCK. At the same edges it samples `miso`. When the frame ends, the block pulses `frame_done` for one cycle and presents the received bits right-aligned on `rx_data`.

A run/stop input gates the acceptance of new entries. A stop request that arrives during a frame takes effect only once that frame is complete. A master-enable input decides whether the block drives the bus at all.

Top module: `spi_cmd_master`

## Requirements
- R1: While reset is held and right after it is released, all chip selects are high, `sck` and `mosi` are low, `frame_done` is low, `running` is low and `ent_ready` is low.
- R2: `ent_ready` is high only when the block is idle, `running` is high and `master_en` is high. An entry is accepted at the clock edge where `ent_valid` and `ent_ready` are both high. `frame_done` then rises exactly 2·N·(D+1) cycles after that edge. Here N is the frame length and D is the divider of the set that `ent_sel` picked.
- R3: From the cycle after acceptance until the frame ends, only `cs_n[ent_sel]` is low. All chip selects are high while `frame_done` is high and at all times between frames.
- R4: SCK behaves as follows during a frame:
  - At acceptance it takes the level CPOL xor CPHA.
  - It toggles every D+1 cycles, giving 2·N half periods.
  - It rests at CPOL after the frame.
  - Each `mosi` bit stays stable across the SCK edge that moves SCK to the level not(CPOL xor CPHA).
  - With the LSB-first flag clear, data bit N-1 is sent first. With the flag set, bit 0 is sent first.
  - Data bits at N and above are not sent.
- R5: `miso` is sampled at the same edges as in R4. After the frame, `rx_data` holds the N received bits right-aligned, with zeros above them. The first bit received ends up at position N-1 when MSB-first and at position 0 when LSB-first.
- R6: `frame_done` is high for exactly one cycle per completed frame.
- R7: Changes on `run_req` reach `running` as follows:
  - While idle, `running` follows `run_req` one cycle later.
  - While a frame is in progress, and at the edge that accepts a frame, `running` holds its value.
  - A pending stop is applied at the edge that ends the frame, so `running` is low in the same cycle that `frame_done` is high.
- R8: While `running` is low, `ent_ready` stays low, pending entries are left untouched and no chip select is asserted. After `run_req` returns high, the next entry offered is accepted and transferred normally.
- R9: Configuration writes work as follows:
  - A write with `cfg_we` high stores all fields into the set `cfg_sel`.
  - A write whose length lies outside 4 to 16 is discarded whole.
  - A frame uses the attributes captured at its acceptance, so a write during a frame affects only later frames.
- R10: While `master_en` is low, `ent_ready`, `sck` and `mosi` are low and all chip selects are high. A frame in progress when `master_en` falls is abandoned without a `frame_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Lets the block act as bus master |
| run_req | input | 1 | Run (1) or stop (0) request |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_sel | input | 2 | Attribute set to write |
| cfg_len | input | 5 | Frame length in bits, 4 to 16 |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | SCK phase |
| cfg_lsb_first | input | 1 | Send least significant bit first |
| cfg_div | input | 8 | Half period of SCK minus one, in clock cycles |
| ent_valid | input | 1 | Entry offered |
| ent_ready | output | 1 | Entry can be accepted this cycle |
| ent_sel | input | 2 | Attribute set and chip select for this frame |
| ent_data | input | 16 | Transmit data, right-aligned |
| running | output | 1 | Run state after deferral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| frame_done | output | 1 | One-cycle frame completion pulse |
| rx_data | output | 16 | Received bits of the last frame, right-aligned |

## Verification
Each result is due at a known cycle:
- `running` responds one edge after a `run_req` change while idle, and at the frame-ending edge otherwise.
- The chip select falls one edge after acceptance.
- `frame_done` and `rx_data` appear 2·N·(D+1) edges after acceptance.

The bench drives inputs and samples outputs on the falling clock edge, so it sees the state one edge later. It measures the acceptance-to-done distance by counting falling edges from the first one after the accepting edge, and compares that count with the table value. A monitor watches `sck` itself and captures `mosi` at each sampling transition, which checks bit order and length without assuming where in the cycle the shift register moves.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int unsigned SPI_MAX_BITS = 16;
   localparam int unsigned SPI_DIV_W    = 8;
   localparam int unsigned SPI_LEN_W    = $clog2(SPI_MAX_BITS + 1);
   localparam int unsigned SPI_HALF_W   = SPI_LEN_W + 1;

   typedef struct packed {
      logic [SPI_LEN_W-1:0] len;
      logic                 cpol;
      logic                 cpha;
      logic                 lsb_first;
      logic [SPI_DIV_W-1:0] div;
   } spi_attr_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } spi_state_e;
endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
   import spi_cmd_pkg::*;
#(
   parameter int unsigned NUM_SETS = 4,
   parameter int unsigned MIN_BITS = 4,
   parameter int unsigned DEF_BITS = 8,
   localparam int unsigned SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  spi_attr_t        wr_attr,
   input  logic [SEL_W-1:0] rd_sel,
   output spi_attr_t        rd_attr
);
   localparam logic [SPI_LEN_W-1:0] LEN_LO  = SPI_LEN_W'(MIN_BITS);
   localparam logic [SPI_LEN_W-1:0] LEN_HI  = SPI_LEN_W'(SPI_MAX_BITS);
   localparam logic [SPI_LEN_W-1:0] LEN_DEF = SPI_LEN_W'(DEF_BITS);

   if (MIN_BITS < 2 || MIN_BITS > SPI_MAX_BITS) begin : g_bad_min
      $error("spi_attr_bank: MIN_BITS out of range");
   end
   if (DEF_BITS < MIN_BITS || DEF_BITS > SPI_MAX_BITS) begin : g_bad_def
      $error("spi_attr_bank: DEF_BITS out of range");
   end

   spi_attr_t set_q [NUM_SETS];
   logic      len_ok;

   assign len_ok  = (wr_attr.len >= LEN_LO) && (wr_attr.len <= LEN_HI);
   assign rd_attr = set_q[rd_sel];

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            set_q[g]     <= '0;
            set_q[g].len <= LEN_DEF;
         end else if (wr_en && (wr_sel == SEL_W'(g)) && len_ok) begin
            set_q[g] <= wr_attr;
         end
      end

      // R9: a stored length never leaves the legal range
      p_len_range_r9 : assert property (@(posedge clk) disable iff (!rst_n)
         (set_q[g].len >= LEN_LO) && (set_q[g].len <= LEN_HI));
   end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
   import spi_cmd_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [SPI_DIV_W-1:0] load_div,
   input  logic                 run,
   input  logic [SPI_DIV_W-1:0] reload_div,
   output logic                 step
);
   logic [SPI_DIV_W-1:0] cnt_q;

   assign step = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_div;
      end else if (step) begin
         cnt_q <= reload_div;
      end else if (run) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R2: every half period restarts from the frame's divider
   p_step_reload_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt_q == $past(reload_div)));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
   import spi_cmd_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [SPI_MAX_BITS-1:0] load_data,
   input  logic [SPI_LEN_W-1:0]    load_len,
   input  logic                    load_lsb,
   input  logic [SPI_LEN_W-1:0]    frm_len,
   input  logic                    frm_lsb,
   input  logic                    shift_en,
   input  logic                    sample_en,
   input  logic                    miso,
   output logic                    mosi,
   output logic [SPI_MAX_BITS-1:0] rx_word
);
   localparam logic [SPI_LEN_W-1:0] FULL = SPI_LEN_W'(SPI_MAX_BITS);

   logic [SPI_MAX_BITS-1:0] tx_q;
   logic [SPI_MAX_BITS-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else if (load) begin
         tx_q <= load_lsb ? load_data : (load_data << (FULL - load_len));
         rx_q <= '0;
      end else begin
         if (shift_en) begin
            tx_q <= frm_lsb ? (tx_q >> 1) : (tx_q << 1);
         end
         if (sample_en) begin
            rx_q <= frm_lsb ? {miso, rx_q[SPI_MAX_BITS-1:1]}
                            : {rx_q[SPI_MAX_BITS-2:0], miso};
         end
      end
   end

   assign mosi    = frm_lsb ? tx_q[0] : tx_q[SPI_MAX_BITS-1];
   assign rx_word = frm_lsb ? (rx_q >> (FULL - frm_len)) : rx_q;

   // R4: the serial output moves only on a load or a shift
   p_mosi_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !load && $stable(frm_lsb)) |=> $stable(mosi));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
   import spi_cmd_pkg::*;
#(
   parameter int unsigned NUM_SETS = 4,
   parameter int unsigned MIN_BITS = 4,
   localparam int unsigned SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    master_en,
   input  logic                    run_req,
   input  logic                    cfg_we,
   input  logic [SEL_W-1:0]        cfg_sel,
   input  logic [SPI_LEN_W-1:0]    cfg_len,
   input  logic                    cfg_cpol,
   input  logic                    cfg_cpha,
   input  logic                    cfg_lsb_first,
   input  logic [SPI_DIV_W-1:0]    cfg_div,
   input  logic                    ent_valid,
   output logic                    ent_ready,
   input  logic [SEL_W-1:0]        ent_sel,
   input  logic [SPI_MAX_BITS-1:0] ent_data,
   output logic                    running,
   output logic                    sck,
   output logic                    mosi,
   input  logic                    miso,
   output logic [NUM_SETS-1:0]     cs_n,
   output logic                    frame_done,
   output logic [SPI_MAX_BITS-1:0] rx_data
);
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("spi_cmd_master: NUM_SETS must be a power of two, at least 2");
   end

   spi_attr_t                wr_attr, rd_attr, cur_q;
   spi_state_e               state_q;
   logic [SEL_W-1:0]         sel_q;
   logic [SPI_HALF_W-1:0]    half_q, half_nx, half_last;
   logic                     sck_q, run_q, done_q;
   logic [SPI_MAX_BITS-1:0]  rx_q, rx_word;
   logic                     accept, step, last, frame_end;
   logic                     shift_en, sample_en, drive, core_mosi;

   assign wr_attr = '{len: cfg_len, cpol: cfg_cpol, cpha: cfg_cpha,
                      lsb_first: cfg_lsb_first, div: cfg_div};

   spi_attr_bank #(.NUM_SETS(NUM_SETS), .MIN_BITS(MIN_BITS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
      .wr_attr(wr_attr), .rd_sel(ent_sel), .rd_attr(rd_attr));

   assign ent_ready = (state_q == ST_IDLE) && run_q && master_en;
   assign accept    = ent_valid && ent_ready;

   spi_half_timer u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_div(rd_attr.div),
      .run((state_q == ST_XFER) && master_en), .reload_div(cur_q.div),
      .step(step));

   assign half_nx   = half_q + 1'b1;
   assign half_last = {cur_q.len, 1'b0} - 1'b1;
   assign last      = (half_q == half_last);
   assign frame_end = step && last;
   assign shift_en  = step && !last && !half_nx[0];
   assign sample_en = step && !last && half_nx[0];

   spi_shift_core u_core (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_data(ent_data),
      .load_len(rd_attr.len), .load_lsb(rd_attr.lsb_first),
      .frm_len(cur_q.len), .frm_lsb(cur_q.lsb_first),
      .shift_en(shift_en), .sample_en(sample_en), .miso(miso),
      .mosi(core_mosi), .rx_word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         sel_q   <= '0;
         half_q  <= '0;
         sck_q   <= 1'b0;
         run_q   <= 1'b0;
         done_q  <= 1'b0;
         rx_q    <= '0;
      end else begin
         done_q <= frame_end;
         if ((state_q == ST_IDLE && !accept) || frame_end) begin
            run_q <= run_req;
         end
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_XFER;
                  cur_q   <= rd_attr;
                  sel_q   <= ent_sel;
                  half_q  <= '0;
                  sck_q   <= rd_attr.cpol ^ rd_attr.cpha;
               end
            end
            ST_XFER: begin
               if (!master_en) begin
                  state_q <= ST_IDLE;
               end else if (frame_end) begin
                  state_q <= ST_IDLE;
                  rx_q    <= rx_word;
                  sck_q   <= cur_q.cpol;
               end else if (step) begin
                  half_q <= half_nx;
                  sck_q  <= cur_q.cpol ^ cur_q.cpha ^ half_nx[0];
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign drive = (state_q == ST_XFER) && master_en;

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_cs
      assign cs_n[g] = !(drive && (sel_q == SEL_W'(g)));
   end

   assign sck        = master_en && sck_q;
   assign mosi       = drive && core_mosi;
   assign running    = run_q;
   assign frame_done = done_q;
   assign rx_data    = rx_q;

   // R3: never more than one chip select active
   p_cs_onehot_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R3: chip selects released when a frame completes
   p_cs_done_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (cs_n == '1));
   // R6: completion is a single-cycle pulse
   p_done_pulse_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   // R7: run state frozen inside a frame
   p_defer_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_XFER) && master_en && !frame_end) |=> (running == $past(running)));
   // R8: stopped block offers no acceptance
   p_stop_gate_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !ent_ready);
   // R10: bus released without master mode
   p_master_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> ((cs_n == '1) && !ent_ready && !sck && !mosi));
endmodule

// File: tb/spi_cmd_master_bench.sv
`timescale 1ns/1ps
module spi_cmd_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b0, run_req = 1'b0;
   logic        cfg_we = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [4:0]  cfg_len = '0;
   logic [7:0]  cfg_div = '0;
   logic        ent_valid = 1'b0, ent_ready;
   logic [1:0]  ent_sel = '0;
   logic [15:0] ent_data = '0;
   logic        running, sck, mosi, miso, frame_done;
   logic [3:0]  cs_n;
   logic [15:0] rx_data;

   int n_chk = 0, n_fail = 0;

   logic        b_cpol [4], b_cpha [4], b_lsb [4];

   logic        mon_en = 1'b0, mon_lvl = 1'b0, mon_lsb = 1'b0;
   int          mon_n = 0;
   logic [15:0] mon_word = '0;

   always #2 clk = ~clk;

   assign miso = ~mosi;

   spi_cmd_master u_spi_cmd_master (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .run_req(run_req),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_len(cfg_len), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb), .cfg_div(cfg_div),
      .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_sel(ent_sel),
      .ent_data(ent_data), .running(running), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n), .frame_done(frame_done), .rx_data(rx_data));

   always @(sck) begin
      if (mon_en && sck === mon_lvl) begin
         if (mon_lsb) mon_word[mon_n] = mosi;
         else         mon_word = {mon_word[14:0], mosi};
         mon_n++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_set(input logic [1:0] s, input logic [4:0] len, input logic pol,
                            input logic pha, input logic lsb, input logic [7:0] div);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_len = len; cfg_cpol = pol;
      cfg_cpha = pha; cfg_lsb = lsb; cfg_div = div;
      if (len >= 5'd4 && len <= 5'd16) begin
         b_cpol[s] = pol; b_cpha[s] = pha; b_lsb[s] = lsb;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic frame(input logic [1:0] s, input logic [15:0] d, input int len,
                        input int exp_cyc, input string tag);
      int          cyc;
      logic [15:0] mask;
      logic [3:0]  cs_first;
      mask = 16'((32'h1 << len) - 1);
      @(negedge clk);
      ent_sel = s; ent_data = d; ent_valid = 1'b1;
      while (!ent_ready) @(negedge clk);
      mon_n = 0; mon_word = '0; mon_lsb = b_lsb[s];
      mon_lvl = ~(b_cpol[s] ^ b_cpha[s]); mon_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ent_valid = 1'b0;
      cs_first = cs_n;
      cyc = 0;
      while (!frame_done) begin
         @(negedge clk);
         cyc++;
      end
      mon_en = 1'b0;
      chk({tag, " R2 cycles"}, cyc, exp_cyc);
      chk({tag, " R3 cs"}, {28'h0, cs_first}, {28'h0, ~(4'b1 << s)});
      chk({tag, " R3 cs released"}, {28'h0, cs_n}, 32'hF);
      chk({tag, " R4 bit count"}, mon_n, len);
      chk({tag, " R4 bits out"}, {16'h0, mon_word}, {16'h0, d & mask});
      chk({tag, " R4 sck rest"}, {31'h0, sck}, {31'h0, b_cpol[s]});
      chk({tag, " R5 rx"}, {16'h0, rx_data}, {16'h0, ~d & mask});
      @(negedge clk);
      chk({tag, " R6 pulse"}, {31'h0, frame_done}, 32'h0);
   endtask

   // {sel, data, len, cycles}
   localparam logic [30:0] VEC [7] = '{
      {2'd0, 16'h003A, 5'd8,  8'd32},
      {2'd1, 16'hB2D1, 5'd16, 8'd32},
      {2'd2, 16'h000D, 5'd4,  8'd24},
      {2'd3, 16'h0A63, 5'd12, 8'd96},
      {2'd0, 16'hF217, 5'd8,  8'd32},
      {2'd2, 16'hFFF4, 5'd4,  8'd24},
      {2'd1, 16'h0001, 5'd16, 8'd32}
   };

   initial begin
      #(4 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic done_seen;
      for (int i = 0; i < 4; i++) begin b_cpol[i] = 0; b_cpha[i] = 0; b_lsb[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R1 cs in reset", {28'h0, cs_n}, 32'hF);
      chk("R1 sck in reset", {31'h0, sck}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cs", {28'h0, cs_n}, 32'hF);
      chk("R1 done", {31'h0, frame_done}, 32'h0);
      chk("R1 running", {31'h0, running}, 32'h0);
      chk("R1 ready", {31'h0, ent_ready}, 32'h0);
      chk("R1 mosi", {31'h0, mosi}, 32'h0);

      master_en = 1'b1; run_req = 1'b1;
      @(negedge clk);
      chk("R7 run follows when idle", {31'h0, running}, 32'h1);

      write_set(2'd0, 5'd8,  1'b0, 1'b0, 1'b0, 8'd1);
      write_set(2'd1, 5'd16, 1'b1, 1'b0, 1'b1, 8'd0);
      write_set(2'd2, 5'd4,  1'b0, 1'b1, 1'b0, 8'd2);
      write_set(2'd3, 5'd12, 1'b1, 1'b1, 1'b1, 8'd3);

      for (int i = 0; i < 7; i++) begin
         frame(VEC[i][30:29], VEC[i][28:13], int'(VEC[i][12:8]), int'(VEC[i][7:0]), "table");
      end

      // R9: illegal lengths discard the whole write
      write_set(2'd0, 5'd3,  1'b0, 1'b0, 1'b0, 8'd5);
      write_set(2'd0, 5'd17, 1'b0, 1'b0, 1'b0, 8'd5);
      frame(2'd0, 16'h0059, 8, 32, "R9 bad len");

      // R9: write during a frame touches only later frames
      fork
         frame(2'd2, 16'h0009, 4, 24, "R9 mid-frame");
         begin
            repeat (6) @(negedge clk);
            write_set(2'd2, 5'd4, 1'b0, 1'b1, 1'b0, 8'd0);
         end
      join
      frame(2'd2, 16'h0009, 4, 8, "R9 next frame");

      // R7: stop deferred to the frame boundary
      fork
         frame(2'd3, 16'h0C35, 12, 96, "R7 defer");
         begin
            repeat (10) @(negedge clk);
            run_req = 1'b0;
            repeat (20) @(negedge clk);
            chk("R7 held mid-frame", {31'h0, running}, 32'h1);
         end
      join
      // frame() returned one cycle after the done cycle
      chk("R7 stopped at boundary", {31'h0, running}, 32'h0);

      // R8: stopped block ignores the offered entry
      ent_sel = 2'd1; ent_data = 16'h1234; ent_valid = 1'b1;
      done_seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ent_ready || cs_n != 4'hF) done_seen = 1'b1;
      end
      chk("R8 entry ignored while stopped", {31'h0, done_seen}, 32'h0);
      run_req = 1'b1;
      @(negedge clk);
      chk("R8 run resumes", {31'h0, running}, 32'h1);
      frame(2'd0, 16'h00E1, 8, 32, "R8 resume");

      // R7: stop while idle is immediate
      run_req = 1'b0;
      @(negedge clk);
      chk("R7 idle stop", {31'h0, running}, 32'h0);
      run_req = 1'b1;
      @(negedge clk);

      // R10: master mode off
      master_en = 1'b0;
      @(negedge clk);
      chk("R10 ready low", {31'h0, ent_ready}, 32'h0);
      chk("R10 cs high", {28'h0, cs_n}, 32'hF);
      chk("R10 sck low", {31'h0, sck}, 32'h0);
      master_en = 1'b1;
      ent_sel = 2'd3; ent_data = 16'h0F0F; ent_valid = 1'b1;
      @(negedge clk);
      while (!ent_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      ent_valid = 1'b0;
      chk("R10 frame started", {28'h0, cs_n}, 32'h7);
      repeat (10) @(negedge clk);
      master_en = 1'b0;
      @(negedge clk);
      chk("R10 abandon cs", {28'h0, cs_n}, 32'hF);
      done_seen = 1'b0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (frame_done) done_seen = 1'b1;
      end
      chk("R10 no done after abandon", {31'h0, done_seen}, 32'h0);
      master_en = 1'b1;
      frame(2'd0, 16'h0093, 8, 32, "R10 after re-enable");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule